// File: doc/BRIEF.md
# Phantom Real-Time Clock Access Sequencer

This block runs the serial protocol of a real-time clock chip that has no data lines of its own and is reached only through a small memory window. The block is the bus master. It sends a bit by reading one of two addresses just below the window base: base-4 means zero and base-3 means one. It receives a bit by reading the base address and taking data bit 0. Each transaction runs in a fixed order. First comes one throw-away read at the base. Then a 64-bit unlock pattern is sent. Last, an 8-byte packed-BCD time record is moved in one direction or the other.

The host keeps six binary time registers: seconds, minutes, hours, date, month and year, each 0 to 99. A write command loads these registers from the set inputs and sends the same values to the chip. A read command fetches the record from the chip and converts it back into the registers. The block also keeps the host time aligned without help. It runs a read right after reset, and again whenever a seconds tick arrives while seconds sits at 59. The busy output lets other masters be held off the bus for the whole sequence, because an interrupted sequence leaves the chip out of step.

Top module: `rtc_phantom_seq`

## Requirements
- R1: A start pulse is accepted only while busy is low. Busy rises on the next cycle, and the write/read select and the set inputs are sampled in that same cycle. A start pulse during a transaction has no effect on the transaction or on anything that follows.
- R2: The first bus access of every transaction is a read at the base address. Its data is discarded.
- R3: Accesses 2 to 65 send the unlock bytes C5, 3A, A3, 5C, C5, 3A, A3, 5C, in that order and least significant bit first. A 0 bit is an access at base-4 and a 1 bit is an access at base-3.
- R4: Each access holds its address for SETUP_CYC cycles with the strobe low, then raises the strobe for exactly one cycle. The read bit is sampled in the cycle after the strobe. Consecutive strobes in a transaction are SETUP_CYC+2 cycles apart.
- R5: A write sends 8 bytes after the unlock, in this order: sub-second, seconds, minutes, hours, day-of-week, date, month, year. Each byte goes least significant bit first as packed BCD, with tens in bits 7:4 and units in bits 3:0. The sub-second and day-of-week bytes are sent as 00. The time registers take the set values when the write is accepted.
- R6: A read makes 64 accesses at the base address after the unlock and assembles bytes least significant bit first. Each byte is converted from BCD to binary and stored by its position. The sub-second and day-of-week bytes change no register.
- R7: Every transaction makes exactly 129 accesses. Done pulses for exactly one cycle, 3 cycles after the last strobe, in the same cycle that busy falls.
- R8: A read transaction starts by itself in the first cycle after reset is released.
- R9: A seconds tick below 59 adds one to the seconds register. A tick at 59 leaves seconds unchanged and starts a read, which waits if a transaction is already running.
- R10: The strobe is never high while busy is low. During reset the strobe, done and busy are low and the time registers are zero.
- R11: When a tick-requested read is pending and start is pulsed in the same cycle, the read runs and the start is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Start a transaction |
| cmd_write | input | 1 | 1 = write record to clock, 0 = read it |
| cmd_done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Transaction in progress; lock out other masters |
| sec_tick | input | 1 | One-second tick of the host time base |
| set_sec | input | 7 | Binary seconds to write |
| set_min | input | 7 | Binary minutes to write |
| set_hour | input | 7 | Binary hours to write |
| set_date | input | 7 | Binary day of month to write |
| set_month | input | 7 | Binary month to write |
| set_year | input | 7 | Binary year (0-99) to write |
| time_sec | output | 7 | Host seconds register |
| time_min | output | 7 | Host minutes register |
| time_hour | output | 7 | Host hours register |
| time_date | output | 7 | Host date register |
| time_month | output | 7 | Host month register |
| time_year | output | 7 | Host year register |
| bus_addr | output | ADDR_W | Access address |
| bus_strobe | output | 1 | One-cycle access strobe |
| bus_rbit | input | 1 | Bit 0 of read data |

## Verification
The bench records the address of every strobe, so the sequence can be compared bit by bit. Write records include 0, 9/10, 59 and 99, which separate wrong BCD digit carries and also show up any lost or reordered byte slots. The read records the bench model returns place junk in the sub-second and day-of-week slots, so a store made at the wrong index shows up as a corrupted register. Further directed cases cover the automatic read after reset, a start ignored while busy, seconds ticking up to 59 and then forcing a read, and a pending tick-requested read competing with a command start.

// File: rtl/rtc_phantom_pkg.sv
package rtc_phantom_pkg;

    localparam int VAL_W        = 7;
    localparam int REC_BYTES    = 8;
    localparam int UNLOCK_BYTES = 8;
    localparam int UNLOCK_BITS  = UNLOCK_BYTES * 8;
    localparam int REC_BITS     = REC_BYTES * 8;
    localparam int ACC_TOTAL    = 1 + UNLOCK_BITS + REC_BITS;
    localparam int IDX_W        = $clog2(ACC_TOTAL);
    localparam int SLOT_W       = $clog2(REC_BYTES);

    typedef enum logic [1:0] {
        ACC_READ = 2'd0,
        ACC_ZERO = 2'd1,
        ACC_ONE  = 2'd2
    } acc_kind_t;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_RUN,
        SEQ_FINISH
    } seq_state_t;

    typedef struct packed {
        logic [VAL_W-1:0] year;
        logic [VAL_W-1:0] month;
        logic [VAL_W-1:0] date;
        logic [VAL_W-1:0] hour;
        logic [VAL_W-1:0] mins;
        logic [VAL_W-1:0] sec;
    } time_rec_t;

    // record slot order on the wire
    localparam logic [SLOT_W-1:0] SLOT_SUBSEC = 3'd0;
    localparam logic [SLOT_W-1:0] SLOT_SEC    = 3'd1;
    localparam logic [SLOT_W-1:0] SLOT_MIN    = 3'd2;
    localparam logic [SLOT_W-1:0] SLOT_HOUR   = 3'd3;
    localparam logic [SLOT_W-1:0] SLOT_DOW    = 3'd4;
    localparam logic [SLOT_W-1:0] SLOT_DATE   = 3'd5;
    localparam logic [SLOT_W-1:0] SLOT_MONTH  = 3'd6;
    localparam logic [SLOT_W-1:0] SLOT_YEAR   = 3'd7;

    // the unlock key repeats a four-byte group twice
    function automatic logic [7:0] unlock_byte(input logic [2:0] n);
        logic [7:0] b;
        case (n[1:0])
            2'd0:    b = 8'hC5;
            2'd1:    b = 8'h3A;
            2'd2:    b = 8'hA3;
            default: b = 8'h5C;
        endcase
        return b;
    endfunction

    function automatic logic [7:0] bin_to_bcd(input logic [VAL_W-1:0] v);
        logic [VAL_W-1:0] tens;
        logic [VAL_W-1:0] ones;
        tens = v / 7'd10;
        ones = v - tens * 7'd10;
        return {tens[3:0], ones[3:0]};
    endfunction

    function automatic logic [VAL_W-1:0] bcd_to_bin(input logic [7:0] b);
        logic [7:0] acc;
        acc = {4'd0, b[7:4]} * 8'd10 + {4'd0, b[3:0]};
        return acc[VAL_W-1:0];
    endfunction

    function automatic logic [7:0] rec_slot_byte(input time_rec_t r, input logic [SLOT_W-1:0] slot);
        logic [7:0] b;
        case (slot)
            SLOT_SEC:   b = bin_to_bcd(r.sec);
            SLOT_MIN:   b = bin_to_bcd(r.mins);
            SLOT_HOUR:  b = bin_to_bcd(r.hour);
            SLOT_DATE:  b = bin_to_bcd(r.date);
            SLOT_MONTH: b = bin_to_bcd(r.month);
            SLOT_YEAR:  b = bin_to_bcd(r.year);
            default:    b = 8'h00;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/rtc_bus_access.sv
module rtc_bus_access
    import rtc_phantom_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter int unsigned BASE_ADDR = 32'h0000FF7C,
    parameter int          SETUP_CYC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  acc_kind_t         kind,
    input  logic              bus_rbit,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_strobe,
    output logic              acc_done,
    output logic              acc_bit
);

    localparam int LAST_CNT = SETUP_CYC + 1;
    localparam int CNT_W    = $clog2(LAST_CNT + 1);
    localparam logic [ADDR_W-1:0] A_READ = ADDR_W'(BASE_ADDR);
    localparam logic [ADDR_W-1:0] A_ZERO = ADDR_W'(BASE_ADDR - 4);
    localparam logic [ADDR_W-1:0] A_ONE  = ADDR_W'(BASE_ADDR - 3);

    logic             active;
    logic [CNT_W-1:0] cnt;
    acc_kind_t        kind_q;
    logic             at_end;

    assign at_end = active && (cnt == CNT_W'(LAST_CNT));

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
            kind_q <= ACC_READ;
        end else if (go && (!active || at_end)) begin
            active <= 1'b1;
            cnt    <= '0;
            kind_q <= kind;
        end else if (at_end) begin
            active <= 1'b0;
        end else if (active) begin
            cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        case (kind_q)
            ACC_ZERO: bus_addr = active ? A_ZERO : A_READ;
            ACC_ONE:  bus_addr = active ? A_ONE  : A_READ;
            default:  bus_addr = A_READ;
        endcase
    end

    assign bus_strobe = active && (cnt == CNT_W'(SETUP_CYC));
    assign acc_done   = at_end;
    assign acc_bit    = bus_rbit;

    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        bus_strobe |=> !bus_strobe);                                      // R4

    AST_GO_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        go |-> (!active || at_end));                                      // R4

    generate
        if (SETUP_CYC > 0) begin : g_setup_chk
            AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
                bus_strobe |-> $stable(bus_addr));                        // R4
        end
    endgenerate

endmodule

// File: rtl/rtc_rx_shift.sv
module rtc_rx_shift (
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       shift_en,
    input  logic       bit_in,
    output logic       byte_valid,
    output logic [7:0] byte_q
);

    logic [7:0] sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr         <= 8'h80;
            byte_valid <= 1'b0;
            byte_q     <= 8'h00;
        end else if (clear) begin
            sr         <= 8'h80;
            byte_valid <= 1'b0;
        end else begin
            byte_valid <= 1'b0;
            if (shift_en) begin
                if (sr[0]) begin
                    byte_q     <= {bit_in, sr[7:1]};
                    byte_valid <= 1'b1;
                    sr         <= 8'h80;
                end else begin
                    sr <= {bit_in, sr[7:1]};
                end
            end
        end
    end

    AST_MARKER_KEPT: assert property (@(posedge clk) disable iff (rst)
        sr != 8'h00);                                                     // R6

endmodule

// File: rtl/rtc_seq_ctrl.sv
module rtc_seq_ctrl
    import rtc_phantom_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      launch,
    input  logic      launch_write,
    input  time_rec_t tx_in,
    input  logic      acc_done,
    output logic      acc_go,
    output acc_kind_t acc_kind,
    output logic      rx_shift,
    output logic      rx_clear,
    output logic      seq_busy,
    output logic      seq_done
);

    localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(ACC_TOTAL - 1);
    localparam logic [IDX_W-1:0] XFER_BASE = IDX_W'(UNLOCK_BITS + 1);

    seq_state_t       state;
    logic [IDX_W-1:0] idx;
    logic             mode_wr;
    time_rec_t        tx_rec;

    logic             last_acc;
    logic [IDX_W-1:0] next_idx;
    logic             next_wr;
    time_rec_t        next_rec;

    function automatic acc_kind_t kind_for(input logic [IDX_W-1:0] i,
                                           input logic wr, input time_rec_t r);
        logic [IDX_W-1:0] u;
        logic [7:0]       byt;
        logic             b;
        u   = '0;
        byt = 8'h00;
        b   = 1'b0;
        if (i == '0) return ACC_READ;
        if (i < XFER_BASE) begin
            u   = i - 1'b1;
            byt = unlock_byte(u[5:3]);
            b   = byt[u[2:0]];
        end else begin
            if (!wr) return ACC_READ;
            u   = i - XFER_BASE;
            byt = rec_slot_byte(r, u[5:3]);
            b   = byt[u[2:0]];
        end
        return b ? ACC_ONE : ACC_ZERO;
    endfunction

    assign last_acc = (idx == LAST_IDX);
    assign next_idx = (state == SEQ_IDLE) ? '0 : idx + 1'b1;
    assign next_wr  = (state == SEQ_IDLE) ? launch_write : mode_wr;
    assign next_rec = (state == SEQ_IDLE) ? tx_in : tx_rec;

    assign acc_kind = kind_for(next_idx, next_wr, next_rec);
    assign acc_go   = ((state == SEQ_IDLE) && launch) ||
                      ((state == SEQ_RUN) && acc_done && !last_acc);
    assign rx_shift = (state == SEQ_RUN) && acc_done && !mode_wr && (idx >= XFER_BASE);
    assign rx_clear = (state == SEQ_IDLE) && launch;
    assign seq_busy = (state != SEQ_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SEQ_IDLE;
            idx      <= '0;
            mode_wr  <= 1'b0;
            tx_rec   <= '0;
            seq_done <= 1'b0;
        end else begin
            seq_done <= 1'b0;
            case (state)
                SEQ_IDLE: begin
                    if (launch) begin
                        state   <= SEQ_RUN;
                        idx     <= '0;
                        mode_wr <= launch_write;
                        tx_rec  <= tx_in;
                    end
                end
                SEQ_RUN: begin
                    if (acc_done) begin
                        if (last_acc) state <= SEQ_FINISH;
                        else          idx   <= idx + 1'b1;
                    end
                end
                default: begin
                    state    <= SEQ_IDLE;
                    seq_done <= 1'b1;
                end
            endcase
        end
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        seq_done |=> !seq_done);                                          // R7

    AST_IDX_BOUND: assert property (@(posedge clk) disable iff (rst)
        idx <= LAST_IDX);                                                 // R7

endmodule

// File: rtl/rtc_phantom_seq.sv
module rtc_phantom_seq
    import rtc_phantom_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter int unsigned BASE_ADDR = 32'h0000FF7C,
    parameter int          SETUP_CYC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_start,
    input  logic              cmd_write,
    output logic              cmd_done,
    output logic              busy,
    input  logic              sec_tick,
    input  logic [6:0]        set_sec,
    input  logic [6:0]        set_min,
    input  logic [6:0]        set_hour,
    input  logic [6:0]        set_date,
    input  logic [6:0]        set_month,
    input  logic [6:0]        set_year,
    output logic [6:0]        time_sec,
    output logic [6:0]        time_min,
    output logic [6:0]        time_hour,
    output logic [6:0]        time_date,
    output logic [6:0]        time_month,
    output logic [6:0]        time_year,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_strobe,
    input  logic              bus_rbit
);

    localparam logic [VAL_W-1:0] SEC_LAST = 7'd59;

    time_rec_t         cur;
    time_rec_t         set_rec;
    logic              pend_sync;
    logic              launch;
    logic              launch_wr;
    logic              seq_busy;
    logic              seq_done;
    logic              acc_go;
    acc_kind_t         acc_kind;
    logic              acc_done;
    logic              acc_bit;
    logic              rx_shift;
    logic              rx_clear;
    logic              rx_valid;
    logic [7:0]        rx_byte;
    logic [SLOT_W-1:0] rx_slot;
    logic [VAL_W-1:0]  rx_bin;

    assign set_rec   = '{year: set_year, month: set_month, date: set_date,
                         hour: set_hour, mins: set_min, sec: set_sec};
    assign launch    = !seq_busy && (pend_sync || cmd_start);
    assign launch_wr = !pend_sync && cmd_write;
    assign rx_bin    = bcd_to_bin(rx_byte);

    rtc_seq_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .launch       (launch),
        .launch_write (launch_wr),
        .tx_in        (set_rec),
        .acc_done     (acc_done),
        .acc_go       (acc_go),
        .acc_kind     (acc_kind),
        .rx_shift     (rx_shift),
        .rx_clear     (rx_clear),
        .seq_busy     (seq_busy),
        .seq_done     (seq_done)
    );

    rtc_bus_access #(
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR),
        .SETUP_CYC (SETUP_CYC)
    ) u_access (
        .clk        (clk),
        .rst        (rst),
        .go         (acc_go),
        .kind       (acc_kind),
        .bus_rbit   (bus_rbit),
        .bus_addr   (bus_addr),
        .bus_strobe (bus_strobe),
        .acc_done   (acc_done),
        .acc_bit    (acc_bit)
    );

    rtc_rx_shift u_rx (
        .clk        (clk),
        .rst        (rst),
        .clear      (rx_clear),
        .shift_en   (rx_shift),
        .bit_in     (acc_bit),
        .byte_valid (rx_valid),
        .byte_q     (rx_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur       <= '0;
            pend_sync <= 1'b1;
            rx_slot   <= '0;
        end else begin
            if (launch) pend_sync <= 1'b0;
            if (sec_tick) begin
                if (cur.sec >= SEC_LAST) pend_sync <= 1'b1;
                else                     cur.sec   <= cur.sec + 1'b1;
            end
            if (launch && launch_wr) cur <= set_rec;

            if (rx_clear)      rx_slot <= '0;
            else if (rx_valid) rx_slot <= rx_slot + 1'b1;

            if (rx_valid) begin
                case (rx_slot)
                    SLOT_SEC:   cur.sec   <= rx_bin;
                    SLOT_MIN:   cur.mins  <= rx_bin;
                    SLOT_HOUR:  cur.hour  <= rx_bin;
                    SLOT_DATE:  cur.date  <= rx_bin;
                    SLOT_MONTH: cur.month <= rx_bin;
                    SLOT_YEAR:  cur.year  <= rx_bin;
                    default: ;
                endcase
            end
        end
    end

    assign busy       = seq_busy;
    assign cmd_done   = seq_done;
    assign time_sec   = cur.sec;
    assign time_min   = cur.mins;
    assign time_hour  = cur.hour;
    assign time_date  = cur.date;
    assign time_month = cur.month;
    assign time_year  = cur.year;

    AST_STROBE_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
        bus_strobe |-> busy);                                             // R10

    AST_SYNC_LAUNCH: assert property (@(posedge clk) disable iff (rst)
        (pend_sync && !busy) |=> busy);                                   // R9

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        cmd_done |-> ($past(busy) && !busy));                             // R7

endmodule

// File: tb/tb_rtc_phantom_seq.sv
module tb_rtc_phantom_seq;

    localparam int ADDR_W = 16;
    localparam logic [15:0] BASE = 16'hFF7C;
    localparam int SETUP = 2;
    localparam int NACC = 129;
    localparam int NVEC = 6;

    // {write, sec, min, hour, date, month, year}
    localparam logic [42:0] VEC [0:NVEC-1] = '{
        {1'b1, 7'd0,  7'd0,  7'd0,  7'd1,  7'd1,  7'd0 },
        {1'b0, 7'd59, 7'd59, 7'd23, 7'd31, 7'd12, 7'd99},
        {1'b1, 7'd9,  7'd10, 7'd19, 7'd20, 7'd9,  7'd90},
        {1'b0, 7'd10, 7'd9,  7'd0,  7'd1,  7'd10, 7'd0 },
        {1'b1, 7'd59, 7'd45, 7'd12, 7'd29, 7'd2,  7'd99},
        {1'b0, 7'd30, 7'd1,  7'd7,  7'd15, 7'd6,  7'd42}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_start = 1'b0, cmd_write = 1'b0, sec_tick = 1'b0;
    logic [6:0] set_sec = '0, set_min = '0, set_hour = '0, set_date = '0, set_month = '0, set_year = '0;
    logic cmd_done, busy, bus_strobe;
    logic bus_rbit = 1'b0;
    logic [6:0] time_sec, time_min, time_hour, time_date, time_month, time_year;
    logic [ADDR_W-1:0] bus_addr;

    int n_chk = 0, n_bad = 0, cyc = 0, n_acc = 0, done_cyc = 0;
    logic [15:0] log_addr [0:255];
    int          log_t    [0:255];
    logic [7:0]  rtc_mem  [0:7];

    always #10 clk = ~clk;

    rtc_phantom_seq #(.ADDR_W(ADDR_W), .BASE_ADDR(32'h0000FF7C), .SETUP_CYC(SETUP)) dut (
        .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_write(cmd_write),
        .cmd_done(cmd_done), .busy(busy), .sec_tick(sec_tick),
        .set_sec(set_sec), .set_min(set_min), .set_hour(set_hour),
        .set_date(set_date), .set_month(set_month), .set_year(set_year),
        .time_sec(time_sec), .time_min(time_min), .time_hour(time_hour),
        .time_date(time_date), .time_month(time_month), .time_year(time_year),
        .bus_addr(bus_addr), .bus_strobe(bus_strobe), .bus_rbit(bus_rbit)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // clock chip model: log every strobe and present the read bit for its sample cycle
    always @(negedge clk) begin
        if (!rst && bus_strobe) begin
            if (n_acc < 256) begin
                log_addr[n_acc] = bus_addr;
                log_t[n_acc]    = cyc;
            end
            if (n_acc >= 65 && n_acc < 129) bus_rbit = rtc_mem[(n_acc-65)/8][(n_acc-65)%8];
            else                            bus_rbit = 1'b0;
            n_acc = n_acc + 1;
        end
    end

    function automatic logic [7:0] bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic logic [7:0] key_byte(input int n);
        case (n % 4)
            0: return 8'hC5;
            1: return 8'h3A;
            2: return 8'hA3;
            default: return 8'h5C;
        endcase
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_done();
        int t = 0;
        while (!cmd_done && t < 3000) begin
            @(negedge clk);
            t++;
        end
        chk("R7 done seen", {63'd0, cmd_done}, 64'd1);
        done_cyc = cyc;
        chk("R7 busy low with done", {63'd0, busy}, 64'd0);
        @(negedge clk);
        chk("R7 done one cycle", {63'd0, cmd_done}, 64'd0);
    endtask

    // exp holds the 8 record bytes, slot i at [8*i +: 8]; used only when wr=1
    task automatic check_seq(input bit wr, input logic [63:0] exp);
        int bad_u = 0, bad_g = 0, bad_d = 0;
        chk("R7 access count", 64'(n_acc), 64'(NACC));
        chk("R2 dummy read address", 64'(log_addr[0]), 64'(BASE));
        for (int k = 0; k < 64; k++) begin
            logic [7:0] kb = key_byte(k / 8);
            logic [15:0] ea = kb[k % 8] ? BASE - 16'd3 : BASE - 16'd4;
            if (log_addr[1+k] !== ea) bad_u++;
        end
        chk("R3 unlock address mismatches", 64'(bad_u), 64'd0);
        for (int k = 1; k < NACC; k++)
            if (log_t[k] - log_t[k-1] != SETUP + 2) bad_g++;
        chk("R4 strobe spacing errors", 64'(bad_g), 64'd0);
        chk("R7 done three cycles after last strobe", 64'(done_cyc - log_t[NACC-1]), 64'd3);
        for (int k = 0; k < 64; k++) begin
            logic [15:0] ea;
            if (wr) ea = exp[k] ? BASE - 16'd3 : BASE - 16'd4;
            else    ea = BASE;
            if (log_addr[65+k] !== ea) bad_d++;
        end
        if (wr) chk("R5 write data address mismatches", 64'(bad_d), 64'd0);
        else    chk("R6 read data address mismatches", 64'(bad_d), 64'd0);
    endtask

    function automatic logic [41:0] regs();
        return {time_sec, time_min, time_hour, time_date, time_month, time_year};
    endfunction

    task automatic load_rtc(input logic [41:0] v);
        rtc_mem[0] = 8'h97;           // junk sub-second
        rtc_mem[1] = bcd(int'(v[41:35]));
        rtc_mem[2] = bcd(int'(v[34:28]));
        rtc_mem[3] = bcd(int'(v[27:21]));
        rtc_mem[4] = 8'h06;           // junk day-of-week
        rtc_mem[5] = bcd(int'(v[20:14]));
        rtc_mem[6] = bcd(int'(v[13:7]));
        rtc_mem[7] = bcd(int'(v[6:0]));
    endtask

    function automatic logic [63:0] wr_bytes(input logic [41:0] v);
        return {bcd(int'(v[6:0])), bcd(int'(v[13:7])), bcd(int'(v[20:14])), 8'h00,
                bcd(int'(v[27:21])), bcd(int'(v[34:28])), bcd(int'(v[41:35])), 8'h00};
    endfunction

    task automatic drive_set(input logic [41:0] v);
        {set_sec, set_min, set_hour, set_date, set_month, set_year} = v;
    endtask

    task automatic run_cmd(input bit wr, input logic [41:0] v);
        n_acc = 0;
        if (wr) drive_set(v); else load_rtc(v);
        @(negedge clk);
        cmd_write = wr;
        cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        chk("R1 busy after start", {63'd0, busy}, 64'd1);
        wait_done();
        check_seq(wr, wr_bytes(v));
        if (wr) chk("R5 registers take written values", 64'(regs()), 64'(v));
        else    chk("R6 registers from clock record", 64'(regs()), 64'(v));
    endtask

    initial begin
        automatic logic [41:0] rec_a = {7'd58, 7'd30, 7'd8, 7'd14, 7'd3, 7'd25};
        automatic logic [41:0] rec_b = {7'd11, 7'd22, 7'd13, 7'd4, 7'd5, 7'd66};
        automatic logic [41:0] rec_c = {7'd5, 7'd31, 7'd8, 7'd14, 7'd3, 7'd25};
        automatic logic [41:0] rec_d = {7'd59, 7'd0, 7'd1, 7'd2, 7'd3, 7'd4};
        automatic logic [41:0] rec_e = {7'd2, 7'd1, 7'd2, 7'd2, 7'd3, 7'd4};
        automatic logic [41:0] rec_0 = {7'd12, 7'd45, 7'd23, 7'd28, 7'd2, 7'd24};

        // reset state
        load_rtc(rec_0);
        repeat (4) @(negedge clk);
        chk("R10 reset strobe", {63'd0, bus_strobe}, 64'd0);
        chk("R10 reset done/busy", {62'd0, cmd_done, busy}, 64'd0);
        chk("R10 reset registers", 64'(regs()), 64'd0);

        // automatic read after reset
        n_acc = 0;
        rst = 1'b0;
        @(negedge clk);
        chk("R8 read starts after reset", {63'd0, busy}, 64'd1);
        wait_done();
        check_seq(1'b0, 64'd0);
        chk("R8 registers after initial read", 64'(regs()), 64'(rec_0));

        // table of vectors
        for (int i = 0; i < NVEC; i++) run_cmd(VEC[i][42], VEC[i][41:0]);

        // start ignored while busy
        n_acc = 0;
        drive_set(rec_a);
        @(negedge clk);
        cmd_write = 1'b1;
        cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        repeat (20) @(negedge clk);
        drive_set(rec_b);
        cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        wait_done();
        check_seq(1'b1, wr_bytes(rec_a));
        chk("R1 late start did not reload registers", 64'(regs()), 64'(rec_a));
        repeat (10) @(negedge clk);
        chk("R1 no transaction after ignored start", {63'd0, busy}, 64'd0);
        chk("R1 no extra accesses", 64'(n_acc), 64'(NACC));

        // seconds tick: 58 -> 59, then 59 forces a read
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
        chk("R9 tick increments seconds", 64'(time_sec), 64'd59);
        chk("R9 no read below rollover", {63'd0, busy}, 64'd0);
        load_rtc(rec_c);
        n_acc = 0;
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
        @(negedge clk);
        chk("R9 tick at 59 starts read", {63'd0, busy}, 64'd1);
        chk("R9 seconds held at 59", 64'(time_sec), 64'd59);
        wait_done();
        check_seq(1'b0, 64'd0);
        chk("R9 registers resynchronised", 64'(regs()), 64'(rec_c));

        // pending resync beats a command start
        run_cmd(1'b1, rec_d);
        load_rtc(rec_e);
        drive_set(rec_b);
        n_acc = 0;
        @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick  = 1'b0;
        cmd_write = 1'b1;
        cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        wait_done();
        check_seq(1'b0, 64'd0);
        chk("R11 resync read won over start", 64'(regs()), 64'(rec_e));
        repeat (10) @(negedge clk);
        chk("R11 dropped start left no transaction", {63'd0, busy}, 64'd0);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule